// File: doc/BRIEF.md
# Banked Single-Port RAM with Two-Requester Arbitration

This block forms one linear word-addressed memory out of several independent single-port RAM banks. Each bank can take exactly one access per cycle, read or write. Two requesters share the memory: a fetch port and a data port. Each can present one access per cycle. When the two accesses fall in different banks, both are served in the same cycle. When they fall in the same bank, the fetch port is served and the data port is held off.

The upper address bits pick the bank and the lower bits pick the word inside it. Every bank has the same size except the last, which may be shorter so that the total size need not be a whole number of banks. The defaults give two 2048-word banks and one 1024-word bank, 5120 words in all.

Each port accepts requests with a valid/ready handshake. The fetch port is never back-pressured. The data port sees `dat_ready` low for a cycle when it loses a bank conflict, and it must then hold its request unchanged until it is accepted. Every accepted request produces exactly one response one cycle later, and that response cannot be stalled. Read data is taken from the bank's output register. An address at or beyond the memory size is accepted without stalling and answered with an error flag.

Top module: `sbank_ram_arb`

## Requirements
- R1: While reset is asserted, neither response valid is high and `dat_ready` is high.
- R2: `fch_ready` is always high, and every fetch request gets a response exactly one cycle later.
- R3: A read from either port returns the word most recently written to that address by either port.
- R4: When both ports request in-range addresses in different banks, `dat_ready` is high and both accesses are performed in that cycle.
- R5: When both ports request in-range addresses in the same bank, `dat_ready` is low and the data-port access is not performed in that cycle, whether it is a read or a write.
- R6: A data request that was stalled and is held unchanged is accepted in the first cycle in which the conflict is gone.
- R7: The bank index is address bits [15:11] and the word offset is bits [10:0]. Equal offsets in different banks are separate storage.
- R8: An address at or above TOTAL_WORDS (0x1400 by default) is accepted without stalling and never conflicts. Its response has the error flag set to 1 and data 0. Such a write changes no stored word.
- R9: The last bank is TOTAL_WORDS minus (banks-1)*BANK_WORDS words deep (1024 by default, 0x1000 to 0x13FF). All of its words, up to TOTAL_WORDS-1, are readable and writable.
- R10: An in-range write produces a response with the error flag 0 and data 0.
- R11: The data port gives a response exactly one cycle after each accepted request, and no response after a cycle with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fch_valid | input | 1 | Fetch request present |
| fch_ready | output | 1 | Fetch request accepted (always 1) |
| fch_addr | input | ADDR_W | Fetch word address |
| fch_we | input | 1 | Fetch request is a write |
| fch_wdata | input | WORD_W | Fetch write data |
| fch_rsp_valid | output | 1 | Fetch response present |
| fch_rsp_data | output | WORD_W | Fetch read data (0 for writes and errors) |
| fch_rsp_err | output | 1 | Fetch address was out of range |
| dat_valid | input | 1 | Data request present |
| dat_ready | output | 1 | Data request accepted this cycle |
| dat_addr | input | ADDR_W | Data word address |
| dat_we | input | 1 | Data request is a write |
| dat_wdata | input | WORD_W | Data write data |
| dat_rsp_valid | output | 1 | Data response present |
| dat_rsp_data | output | WORD_W | Data read data (0 for writes and errors) |
| dat_rsp_err | output | 1 | Data address was out of range |

## Verification
The arbitration is driven with three kinds of address pairs. Pairs in different banks show that both ports are served in parallel. Pairs in the same bank show that only the data port stalls, and a fetch read of the very word the stalled data write targets proves that the losing write was not performed. Pairs in which one address is out of range show that an error never counts as a conflict. Writes and reads at equal offsets in different banks and at the edges of the short last bank tell correct bank decoding apart from aliasing. A swept sequence of mixed bank pairs, with retries after stalls, keeps a reference memory in the scoreboard in step with every response.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

  // Number of banks needed to cover a total word count.
  function automatic int bank_count(input int total_words, input int bank_words);
    return (total_words + bank_words - 1) / bank_words;
  endfunction

  // Depth of the final (possibly shorter) bank.
  function automatic int last_depth(input int total_words, input int bank_words);
    return total_words - (bank_count(total_words, bank_words) - 1) * bank_words;
  endfunction

  // Index width for a RAM of a given depth, never below one bit.
  function automatic int idx_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/sbank_decode.sv
module sbank_decode #(
  parameter int ADDR_W      = 16,
  parameter int OFF_W       = 11,
  parameter int TOTAL_WORDS = 5120,
  localparam int BANK_W     = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  off,
  output logic              in_range
);

  assign bank     = addr[ADDR_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];
  assign in_range = ({1'b0, addr} < (ADDR_W+1)'(TOTAL_WORDS));

endmodule

// File: rtl/sbank_arbiter.sv
module sbank_arbiter #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 5
) (
  input  logic                 f_hit,
  input  logic [BANK_W-1:0]    f_bank,
  input  logic                 d_hit,
  input  logic [BANK_W-1:0]    d_bank,
  output logic [NUM_BANKS-1:0] f_sel,
  output logic [NUM_BANKS-1:0] d_sel,
  output logic                 d_stall
);

  logic clash;

  // Fetch has fixed priority; the data port yields on a shared bank.
  assign clash   = f_hit && d_hit && (f_bank == d_bank);
  assign d_stall = clash;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign f_sel[b] = f_hit && (f_bank == BANK_W'(b));
    assign d_sel[b] = d_hit && !clash && (d_bank == BANK_W'(b));
  end

endmodule

// File: rtl/sbank_ram.sv
module sbank_ram #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 2048,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // One access per cycle; read data lands in the output register.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end

endmodule

// File: rtl/sbank_ram_arb.sv
module sbank_ram_arb
  import sbank_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int BANK_WORDS  = 2048,
  parameter int TOTAL_WORDS = 5120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fch_valid,
  output logic              fch_ready,
  input  logic [ADDR_W-1:0] fch_addr,
  input  logic              fch_we,
  input  logic [WORD_W-1:0] fch_wdata,
  output logic              fch_rsp_valid,
  output logic [WORD_W-1:0] fch_rsp_data,
  output logic              fch_rsp_err,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic              dat_we,
  input  logic [WORD_W-1:0] dat_wdata,
  output logic              dat_rsp_valid,
  output logic [WORD_W-1:0] dat_rsp_data,
  output logic              dat_rsp_err
);

  localparam int OFF_W      = $clog2(BANK_WORDS);
  localparam int BANK_W     = ADDR_W - OFF_W;
  localparam int NUM_BANKS  = bank_count(TOTAL_WORDS, BANK_WORDS);
  localparam int LAST_WORDS = last_depth(TOTAL_WORDS, BANK_WORDS);

  logic [BANK_W-1:0]    f_bank, d_bank;
  logic [OFF_W-1:0]     f_off, d_off;
  logic                 f_in, d_in;
  logic [NUM_BANKS-1:0] f_sel, d_sel;
  logic                 d_stall;
  logic [WORD_W-1:0]    bank_q [NUM_BANKS];

  sbank_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TOTAL_WORDS(TOTAL_WORDS)) u_fdec (
    .addr(fch_addr), .bank(f_bank), .off(f_off), .in_range(f_in));

  sbank_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TOTAL_WORDS(TOTAL_WORDS)) u_ddec (
    .addr(dat_addr), .bank(d_bank), .off(d_off), .in_range(d_in));

  sbank_arbiter #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_arb (
    .f_hit(fch_valid && f_in), .f_bank(f_bank),
    .d_hit(dat_valid && d_in), .d_bank(d_bank),
    .f_sel(f_sel), .d_sel(d_sel), .d_stall(d_stall));

  assign fch_ready = 1'b1;
  assign dat_ready = !d_stall;

  // Bank array: each bank is fed by whichever port owns it this cycle.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int DEPTH_B = (b == NUM_BANKS - 1) ? LAST_WORDS : BANK_WORDS;
    localparam int IDX_B   = idx_width(DEPTH_B);
    logic [OFF_W-1:0] b_off;
    assign b_off = f_sel[b] ? f_off : d_off;
    sbank_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH_B), .IDX_W(IDX_B)) u_ram (
      .clk   (clk),
      .en    (f_sel[b] || d_sel[b]),
      .we    (f_sel[b] ? fch_we : dat_we),
      .idx   (b_off[IDX_B-1:0]),
      .wdata (f_sel[b] ? fch_wdata : dat_wdata),
      .rdata (bank_q[b]));
  end

  // Response tracking, one stage per port.
  logic              f_rd_q, d_rd_q;
  logic [BANK_W-1:0] f_bank_q, d_bank_q;
  logic              d_acc;

  assign d_acc = dat_valid && !d_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fch_rsp_valid <= 1'b0;
      fch_rsp_err   <= 1'b0;
      f_rd_q        <= 1'b0;
      f_bank_q      <= '0;
      dat_rsp_valid <= 1'b0;
      dat_rsp_err   <= 1'b0;
      d_rd_q        <= 1'b0;
      d_bank_q      <= '0;
    end else begin
      fch_rsp_valid <= fch_valid;
      fch_rsp_err   <= fch_valid && !f_in;
      f_rd_q        <= fch_valid && f_in && !fch_we;
      f_bank_q      <= f_bank;
      dat_rsp_valid <= d_acc;
      dat_rsp_err   <= d_acc && !d_in;
      d_rd_q        <= d_acc && d_in && !dat_we;
      d_bank_q      <= d_bank;
    end
  end

  always_comb begin
    fch_rsp_data = '0;
    dat_rsp_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (f_rd_q && f_bank_q == BANK_W'(b)) fch_rsp_data = bank_q[b];
      if (d_rd_q && d_bank_q == BANK_W'(b)) dat_rsp_data = bank_q[b];
    end
  end

endmodule

// File: rtl/sbank_ram_arb_chk.sv
module sbank_ram_arb_chk #(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int BANK_WORDS  = 2048,
  parameter int TOTAL_WORDS = 5120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fch_valid,
  input logic [ADDR_W-1:0] fch_addr,
  input logic              fch_we,
  input logic              fch_rsp_valid,
  input logic [WORD_W-1:0] fch_rsp_data,
  input logic              fch_rsp_err,
  input logic              dat_valid,
  input logic              dat_ready,
  input logic [ADDR_W-1:0] dat_addr,
  input logic              dat_we,
  input logic [WORD_W-1:0] dat_wdata,
  input logic              dat_rsp_valid
);

  localparam int OFF_W = $clog2(BANK_WORDS);

  logic f_ok, d_ok, same_bank;
  assign f_ok      = ({1'b0, fch_addr} < (ADDR_W+1)'(TOTAL_WORDS));
  assign d_ok      = ({1'b0, dat_addr} < (ADDR_W+1)'(TOTAL_WORDS));
  assign same_bank = fch_addr[ADDR_W-1:OFF_W] == dat_addr[ADDR_W-1:OFF_W];

  a_r2_fetch_answered: assert property (@(posedge clk) disable iff (!rst_n)
    fch_valid |=> fch_rsp_valid);

  a_r4_split_banks_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_valid && dat_valid && !same_bank) |-> dat_ready);

  a_r5_shared_bank_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_valid && dat_valid && f_ok && d_ok && same_bank) |-> !dat_ready);

  a_r6_held_request: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_addr) && $stable(dat_we) && $stable(dat_wdata)));

  a_r8_oob_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !d_ok) |-> dat_ready);

  a_r8_oob_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_valid && !f_ok) |=> (fch_rsp_err && fch_rsp_data == '0));

  a_r10_write_rsp_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_valid && fch_we && f_ok) |=> (!fch_rsp_err && fch_rsp_data == '0));

  a_r11_dat_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && dat_ready) |=> dat_rsp_valid);

  a_r11_dat_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_valid && dat_ready) |=> !dat_rsp_valid);

endmodule

bind sbank_ram_arb sbank_ram_arb_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BANK_WORDS(BANK_WORDS), .TOTAL_WORDS(TOTAL_WORDS)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .fch_valid(fch_valid), .fch_addr(fch_addr), .fch_we(fch_we),
  .fch_rsp_valid(fch_rsp_valid), .fch_rsp_data(fch_rsp_data), .fch_rsp_err(fch_rsp_err),
  .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_addr(dat_addr), .dat_we(dat_we),
  .dat_wdata(dat_wdata), .dat_rsp_valid(dat_rsp_valid)
);

// File: tb/sbank_ram_arb_tb_top.sv
`timescale 1ns/1ps
module sbank_ram_arb_tb_top;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 16;
  localparam int TOTAL  = 5120;

  logic clk = 1'b0;
  logic rst_n;
  logic fch_valid, fch_ready, fch_we, fch_rsp_valid, fch_rsp_err;
  logic [ADDR_W-1:0] fch_addr;
  logic [WORD_W-1:0] fch_wdata, fch_rsp_data;
  logic dat_valid, dat_ready, dat_we, dat_rsp_valid, dat_rsp_err;
  logic [ADDR_W-1:0] dat_addr;
  logic [WORD_W-1:0] dat_wdata, dat_rsp_data;

  always #4 clk = ~clk;

  sbank_ram_arb dut_i (.*);

  typedef struct {
    logic [WORD_W-1:0] data;
    logic              err;
    string             tag;
  } exp_t;

  exp_t fq[$];
  exp_t dq[$];
  logic [WORD_W-1:0] model [int];
  int checks = 0;
  int fails  = 0;

  function automatic void chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  function automatic exp_t predict(logic [ADDR_W-1:0] a, logic w, logic [WORD_W-1:0] wd, string tag);
    exp_t e;
    bit oob = (int'(a) >= TOTAL);
    e.err = oob;
    e.tag = tag;
    e.data = '0;
    if (w) begin
      if (!oob) model[int'(a)] = wd;
    end else if (!oob && model.exists(int'(a))) begin
      e.data = model[int'(a)];
    end
    return e;
  endfunction

  task automatic step(input logic fv, input logic [ADDR_W-1:0] fa, input logic fw, input logic [WORD_W-1:0] fd,
                      input logic dv, input logic [ADDR_W-1:0] da, input logic dw, input logic [WORD_W-1:0] dd,
                      input string tag, output bit dacc);
    @(negedge clk);
    fch_valid = fv; fch_addr = fa; fch_we = fw; fch_wdata = fd;
    dat_valid = dv; dat_addr = da; dat_we = dw; dat_wdata = dd;
    #1;
    chk(fch_ready === 1'b1, "R2", "fch_ready", 32'(fch_ready), 1);
    dacc = dv && dat_ready;
    if (fv)   fq.push_back(predict(fa, fw, fd, tag));
    if (dacc) dq.push_back(predict(da, dw, dd, tag));
  endtask

  task automatic idle();
    bit unused;
    step(0, '0, 0, '0, 0, '0, 0, '0, "idle", unused);
  endtask

  // Issue a pair; when the data side stalls, hold it with fetch idle (R6).
  task automatic pair(input logic [ADDR_W-1:0] fa, input logic fw, input logic [WORD_W-1:0] fd,
                      input logic [ADDR_W-1:0] da, input logic dw, input logic [WORD_W-1:0] dd,
                      input string tag);
    bit acc;
    step(1, fa, fw, fd, 1, da, dw, dd, tag, acc);
    if (!acc) begin
      step(0, '0, 0, '0, 1, da, dw, dd, "R6", acc);
      chk(acc, "R6", "held request accepted", 32'(acc), 1);
    end
  endtask

  // Scoreboard monitor: sample after each rising edge.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (rst_n) begin
      if (fq.size() > 0) begin
        e = fq.pop_front();
        chk(fch_rsp_valid === 1'b1, e.tag, "fch_rsp_valid", 32'(fch_rsp_valid), 1);
        chk(fch_rsp_data === e.data, e.tag, "fch_rsp_data", 32'(fch_rsp_data), 32'(e.data));
        chk(fch_rsp_err === e.err, e.tag, "fch_rsp_err", 32'(fch_rsp_err), 32'(e.err));
      end else if (fch_rsp_valid !== 1'b0) begin
        chk(0, "R2", "unexpected fch_rsp_valid", 32'(fch_rsp_valid), 0);
      end
      if (dq.size() > 0) begin
        e = dq.pop_front();
        chk(dat_rsp_valid === 1'b1, e.tag, "dat_rsp_valid", 32'(dat_rsp_valid), 1);
        chk(dat_rsp_data === e.data, e.tag, "dat_rsp_data", 32'(dat_rsp_data), 32'(e.data));
        chk(dat_rsp_err === e.err, e.tag, "dat_rsp_err", 32'(dat_rsp_err), 32'(e.err));
      end else if (dat_rsp_valid !== 1'b0) begin
        chk(0, "R11", "unexpected dat_rsp_valid", 32'(dat_rsp_valid), 0);
      end
    end
  end

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit acc;
    rst_n = 1'b0;
    fch_valid = 0; fch_addr = '0; fch_we = 0; fch_wdata = '0;
    dat_valid = 0; dat_addr = '0; dat_we = 0; dat_wdata = '0;
    repeat (3) @(negedge clk);
    chk(fch_rsp_valid === 1'b0, "R1", "fch_rsp_valid in reset", 32'(fch_rsp_valid), 0);
    chk(dat_rsp_valid === 1'b0, "R1", "dat_rsp_valid in reset", 32'(dat_rsp_valid), 0);
    chk(dat_ready === 1'b1, "R1", "dat_ready in reset", 32'(dat_ready), 1);
    rst_n = 1'b1;

    // R4: different banks in the same cycle, writes then crossed reads (R3, R10)
    step(1, 16'h0010, 1, 16'hA001, 1, 16'h0810, 1, 16'hB002, "R4", acc);
    chk(acc, "R4", "dat_ready on split banks", 32'(acc), 1);
    step(1, 16'h0810, 0, '0, 1, 16'h0010, 0, '0, "R3", acc);
    chk(acc, "R4", "dat_ready on split reads", 32'(acc), 1);

    // R5: shared bank; fetch reads the word the losing data write targets
    step(1, 16'h0030, 1, 16'h1111, 0, '0, 0, '0, "R10", acc);
    step(1, 16'h0030, 0, '0, 1, 16'h0030, 1, 16'hD004, "R5", acc);
    chk(!acc, "R5", "dat_ready on shared bank", 32'(acc), 0);
    step(0, '0, 0, '0, 1, 16'h0030, 1, 16'hD004, "R6", acc);
    chk(acc, "R6", "held write accepted", 32'(acc), 1);
    step(1, 16'h0030, 0, '0, 0, '0, 0, '0, "R3", acc);

    // R5 with a stalled read, then R6 release
    step(1, 16'h0040, 1, 16'h4444, 1, 16'h0010, 0, '0, "R5", acc);
    chk(!acc, "R5", "stalled read", 32'(acc), 0);
    step(0, '0, 0, '0, 1, 16'h0010, 0, '0, "R6", acc);
    chk(acc, "R6", "held read accepted", 32'(acc), 1);

    // R7: same offset, different banks
    pair(16'h0005, 1, 16'h1234, 16'h0805, 1, 16'h5678, "R7");
    pair(16'h1005, 1, 16'h9ABC, 16'h0005, 0, '0, "R7");
    pair(16'h0805, 0, '0, 16'h1005, 0, '0, "R7");

    // R9: edges of the short last bank
    pair(16'h13FF, 1, 16'hEEEE, 16'h0FFF, 1, 16'h0F0F, "R9");
    pair(16'h0000, 1, 16'h0A0A, 16'h1000, 1, 16'h1010, "R9");
    pair(16'h1000, 0, '0, 16'h13FF, 0, '0, "R9");

    // R8: out-of-range never conflicts and writes nothing
    step(1, 16'h1000, 0, '0, 1, 16'h1400, 1, 16'hBAD0, "R8", acc);
    chk(acc, "R8", "oob beside fetch in bank index 2", 32'(acc), 1);
    step(1, 16'hFFFF, 0, '0, 1, 16'h1000, 0, '0, "R8", acc);
    chk(acc, "R8", "oob fetch does not stall data", 32'(acc), 1);
    step(1, 16'h1400, 1, 16'h7777, 0, '0, 0, '0, "R8", acc);
    step(0, '0, 0, '0, 1, 16'h1000, 0, '0, "R8", acc);

    // Swept mixed pairs with retries
    for (int i = 0; i < 48; i++) begin
      pair(16'((i * 397) % TOTAL), 1, 16'(16'hC000 + i),
           16'((i * 211 + 900) % TOTAL), 1, 16'(16'h3000 + i * 7), "R3");
    end
    for (int i = 0; i < 48; i++) begin
      pair(16'((i * 211 + 900) % TOTAL), 0, '0, 16'((i * 397) % TOTAL), 0, '0, "R3");
    end

    idle();
    idle();
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule